// File: doc/BRIEF.md
# Programmable symmetric clock prescaler

The block derives a slow converter clock from a fast peripheral clock. A 5-bit prescale code sets the length of each half-period. A modulo counter wraps once every code+1 input cycles, and every wrap toggles the output. High and low times are therefore always equal, and the total divisor is 2×(code+1), which is always even.

Only codes 0 to 7 are valid. They give total divisors 2, 4, 6, …, 16. Any code of 8 or more is reserved. Such a code raises a flag and runs the divider as if code 7 had been applied.

A new code is picked up only when the counter wraps, so the half-period in progress is never shortened. Logic that runs on the input clock can use the one-cycle tick that marks each rising output edge instead of clocking on the derived signal.

Top module: `prs_clkgen`

## Requirements
- R1: While rst_ni is low, div_clk_o, tick_o and reserved_o are 0. After release, div_clk_o first goes high on the second rising input edge, which is the default code 1 (total ÷4).
- R2: For each code v from 0 to 7, once the code has been picked up, every high time and every low time of div_clk_o lasts exactly v+1 input cycles.
- R3: tick_o is high for exactly the one input cycle in which div_clk_o has just gone from 0 to 1, and it is low in every other cycle.
- R4: reserved_o is 1 in the cycle after a prescale code above 7 is present, and 0 in the cycle after a code from 0 to 7 is present.
- R5: A reserved code (8 to 31) gives high and low times of 8 input cycles each, the same as code 7.
- R6: A code that changes during a half-period does not alter that half-period. The new code sets the length of the half-period that starts at the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 5 | Prescale code; half-period is code+1 cycles |
| div_clk_o | output | 1 | Symmetric divided clock |
| tick_o | output | 1 | One-cycle pulse at each rising edge of div_clk_o |
| reserved_o | output | 1 | Registered flag: the code applied is reserved |

## Verification
The bench builds the block with its default parameters: a 5-bit code, a largest legal code of 7 and a reset code of 1. With these values every legal code can be tried, together with reserved codes just above the limit (8), in the middle of the reserved range (20) and at the top of it (31). A code is changed just after a rising output edge, so the bench can see the current half-period run to its full old length and the next one take the new length.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int PRS_W     = 5;
  localparam int LEGAL_MAX = 7;
  localparam int RST_CODE  = 1;
  typedef logic [PRS_W-1:0] prs_t;
endpackage

// File: rtl/prs_decode.sv
module prs_decode #(
  parameter int W         = prs_pkg::PRS_W,
  parameter int LEGAL_MAX = prs_pkg::LEGAL_MAX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] eff_o,
  output logic         reserved_o
);
  localparam logic [W-1:0] MaxCode = W'(LEGAL_MAX);

  logic is_rsv;
  assign is_rsv = code_i > MaxCode;
  assign eff_o  = is_rsv ? MaxCode : code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reserved_o <= 1'b0;
    else         reserved_o <= is_rsv;
  end

  a_r4_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i > MaxCode) |=> reserved_o);
  a_r4_flag_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i <= MaxCode) |=> !reserved_o);
endmodule

// File: rtl/prs_modcnt.sv
module prs_modcnt #(
  parameter int W         = prs_pkg::PRS_W,
  parameter int LEGAL_MAX = prs_pkg::LEGAL_MAX,
  parameter int RST_CODE  = prs_pkg::RST_CODE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] eff_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, lim_q;

  assign wrap_o = (cnt_q == lim_q);

  // limit reloads only on wrap: running half-period keeps its length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= W'(RST_CODE);
    end else if (wrap_o) begin
      cnt_q <= '0;
      lim_q <= eff_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r6_lim_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(lim_q));
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  a_r5_lim_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q <= W'(LEGAL_MAX));
endmodule

// File: rtl/prs_toggle.sv
module prs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  output logic div_clk_o,
  output logic tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_clk_o <= 1'b0;
      tick_o    <= 1'b0;
    end else begin
      if (wrap_i) div_clk_o <= ~div_clk_o;
      tick_o <= wrap_i & ~div_clk_o;
    end
  end

  a_r3_tick_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (div_clk_o && !$past(div_clk_o)));
  a_r3_rise_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk_o) |-> tick_o);
endmodule

// File: rtl/prs_clkgen.sv
module prs_clkgen #(
  parameter int W         = prs_pkg::PRS_W,
  parameter int LEGAL_MAX = prs_pkg::LEGAL_MAX,
  parameter int RST_CODE  = prs_pkg::RST_CODE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prescale_i,
  output logic         div_clk_o,
  output logic         tick_o,
  output logic         reserved_o
);
  logic [W-1:0] eff;
  logic         wrap;

  prs_decode #(.W(W), .LEGAL_MAX(LEGAL_MAX)) i_decode (
    .clk_i, .rst_ni, .code_i(prescale_i), .eff_o(eff), .reserved_o
  );

  prs_modcnt #(.W(W), .LEGAL_MAX(LEGAL_MAX), .RST_CODE(RST_CODE)) i_modcnt (
    .clk_i, .rst_ni, .eff_i(eff), .wrap_o(wrap)
  );

  prs_toggle i_toggle (
    .clk_i, .rst_ni, .wrap_i(wrap), .div_clk_o, .tick_o
  );

  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!div_clk_o && !tick_o && !reserved_o));
endmodule

// File: tb/test_prs_clkgen.sv
module test_prs_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] code = 5'd1;
  logic       div_clk, tick, rsv;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prs_clkgen i_prs_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(code),
    .div_clk_o(div_clk), .tick_o(tick), .reserved_o(rsv)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // measure one high and the following low time from a rising edge; all samples at negedge
  task automatic measure(input int new_code, output int hi, output int lo, output int tbad);
    tbad = 0;
    do @(negedge clk); while (div_clk !== 1'b0);
    do begin
      @(negedge clk);
      if (div_clk !== 1'b1 && tick === 1'b1) tbad++;
    end while (div_clk !== 1'b1);
    if (tick !== 1'b1) tbad++;
    if (new_code >= 0) code = 5'(new_code);
    hi = 1;
    forever begin
      @(negedge clk);
      if (div_clk !== 1'b1) break;
      hi++;
      if (tick !== 1'b0) tbad++;
    end
    lo = 1;
    if (tick !== 1'b0) tbad++;
    forever begin
      @(negedge clk);
      if (div_clk !== 1'b0) break;
      lo++;
      if (tick !== 1'b0) tbad++;
    end
  endtask

  task automatic t_reset();
    int lows, hi, lo, tb;
    @(negedge clk);
    check(div_clk === 1'b0 && tick === 1'b0 && rsv === 1'b0, "R1 reset outputs",
          {29'd0, div_clk, tick, rsv}, 0);
    rst_n = 1'b1;
    lows = 0;
    forever begin
      @(negedge clk);
      if (div_clk === 1'b1) break;
      lows++;
    end
    check(lows == 1, "R1 first rise at 2nd edge (low samples)", lows, 1);
    check(tick === 1'b1, "R1 tick at first rise", int'(tick), 1);
    hi = 1;
    forever begin
      @(negedge clk);
      if (div_clk !== 1'b1) break;
      hi++;
    end
    check(hi == 2, "R1 default high time", hi, 2);
    measure(-1, hi, lo, tb);
    check(hi == 2 && lo == 2, "R1 default period", hi * 100 + lo, 202);
  endtask

  task automatic t_legal();
    int hi, lo, tb;
    for (int v = 0; v < 8; v++) begin
      code = 5'(v);
      measure(-1, hi, lo, tb);
      for (int k = 0; k < 2; k++) begin
        measure(-1, hi, lo, tb);
        check(hi == v + 1, $sformatf("R2 high time code %0d", v), hi, v + 1);
        check(lo == v + 1, $sformatf("R2 low time code %0d", v), lo, v + 1);
        check(tb == 0, $sformatf("R3 tick placement code %0d", v), tb, 0);
      end
    end
  endtask

  task automatic t_reserved();
    int hi, lo, tb;
    int cs[3] = '{8, 20, 31};
    foreach (cs[i]) begin
      @(negedge clk);
      code = 5'(cs[i]);
      @(negedge clk);
      check(rsv === 1'b1, $sformatf("R4 flag set code %0d", cs[i]), int'(rsv), 1);
      measure(-1, hi, lo, tb);
      measure(-1, hi, lo, tb);
      check(hi == 8 && lo == 8, $sformatf("R5 clamp code %0d", cs[i]), hi * 100 + lo, 808);
      check(tb == 0, "R3 tick under reserved code", tb, 0);
    end
    @(negedge clk);
    code = 5'd7;
    @(negedge clk);
    check(rsv === 1'b0, "R4 flag clear code 7", int'(rsv), 0);
  endtask

  task automatic t_change();
    int hi, lo, tb;
    code = 5'd7;
    measure(-1, hi, lo, tb);
    measure(0, hi, lo, tb);
    check(hi == 8, "R6 running half kept old length", hi, 8);
    check(lo == 1, "R6 next half uses new code", lo, 1);
    measure(5, hi, lo, tb);
    check(hi == 1 && lo == 6, "R6 change 0 to 5", hi * 100 + lo, 106);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_legal();
    t_reserved();
    t_change();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", WD_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule